// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupt sources and a small CPU core. Requests arrive as one-cycle set strobes, one per vector slot. Several sources may be ORed onto a single slot before they reach the block. Each slot latches its strobe into a pending flag. Each slot also carries an enable bit and a one-bit level select. The controller finds the most urgent enabled pending slot and offers it to the CPU as a request line with a vector address. It then tracks which priority levels are in service, so that a handler can be preempted only by a strictly more urgent level.

There are three levels: top, high and low. Only the first two slots can reach the top level. Every other slot chooses between high and low. When a request is acknowledged, the slot's pending flag is cleared and its level is marked in service. An end-of-service strobe from the handler's return retires the most urgent level that is in service. A global enable gates every request.

Top module: `prio_vic`

## Requirements
- R1: While rst_ni is low, irq_o is 0, cur_lvl_o is 0 and every pending flag and in-service mark is cleared.
- R2: vec_o for slot n equals 3 + 8*n (slot 0 gives 0x03, slot 9 gives 0x4B).
- R3: Level encoding. A slot with lvl_sel_i bit set is top level if it is slot 0 or 1, and high level otherwise. A slot with the bit clear is low level. cur_lvl_o reads 0 for idle, 1 for low, 2 for high and 3 for top.
- R4: Among candidates, the one with the highest level is offered.
- R5: Among candidates of equal level, the lowest slot number is offered.
- R6: A request is raised only if its level is strictly above cur_lvl_o. Requests of equal or lower level stay pending and are offered once service drops below them.
- R7: When ack_i is high while irq_o is high, the offered slot's pending flag is cleared and its level is marked in service. At the next clock edge, irq_o falls and cur_lvl_o shows the new level.
- R8: An eoi_i strobe clears the highest in-service level at the next edge.
- R9: Once irq_o is high, it stays high and vec_o holds its value until ack_i. This holds even if a more urgent slot becomes pending in the meantime.
- R10: A slot is a candidate only when both glb_en_i and its en_i bit are set. A masked slot keeps its pending flag and is offered once it is unmasked.
- R11: A strobe sampled at clock edge k raises irq_o after edge k+1, not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global request enable |
| en_i | input | N_SLOTS | Per-slot enable |
| lvl_sel_i | input | N_SLOTS | Per-slot level select (see R3) |
| pend_set_i | input | N_SLOTS | Per-slot request set strobe |
| ack_i | input | 1 | CPU acknowledge of the offered vector |
| eoi_i | input | 1 | End of service (return from handler) |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | ADDR_W | Vector address of the offered slot |
| cur_lvl_o | output | 2 | Highest level currently in service |

## Verification
Three nesting levels are built up in sequence and then unwound, while a low-level request is parked behind an equal level. A design that used greater-or-equal preemption would take the parked request too early. A design that popped the wrong level would release it at the wrong point. A more urgent request is injected while a vector is awaiting acknowledge; a controller that re-arbitrated before the acknowledge would switch vec_o under the CPU. The tests also cover:
- ties at each level;
- a masked pending slot;
- a request made with the global enable off;
- the exact edge on which irq_o rises.

A design that chose the highest slot on a tie, dropped the masked request, or raised irq_o one cycle early would fail these.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LO   = 2'd1,
    LVL_HI   = 2'd2,
    LVL_TOP  = 2'd3
  } lvl_t;
endpackage

// File: rtl/vic_pend_reg.sv
module vic_pend_reg #(
  parameter int N_SLOTS = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] set_i,
  input  logic [N_SLOTS-1:0] clr_i,
  output logic [N_SLOTS-1:0] pend_o
);
  logic [N_SLOTS-1:0] pend_q;

  // a new strobe wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
  import vic_pkg::*;
#(
  parameter int N_SLOTS   = 10,
  parameter int TOP_SLOTS = 2,
  localparam int SW       = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0] cand_i,
  input  logic [N_SLOTS-1:0] sel_i,
  output logic               valid_o,
  output logic [SW-1:0]      slot_o,
  output lvl_t               lvl_o
);
  lvl_t slot_lvl [N_SLOTS];

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_lvl
    if (g < TOP_SLOTS) begin : g_top
      assign slot_lvl[g] = !cand_i[g] ? LVL_NONE : (sel_i[g] ? LVL_TOP : LVL_LO);
    end else begin : g_norm
      assign slot_lvl[g] = !cand_i[g] ? LVL_NONE : (sel_i[g] ? LVL_HI : LVL_LO);
    end
  end

  // scan from the top slot down; >= lets the lower slot win ties
  always_comb begin
    lvl_o  = LVL_NONE;
    slot_o = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (slot_lvl[i] != LVL_NONE && slot_lvl[i] >= lvl_o) begin
        lvl_o  = slot_lvl[i];
        slot_o = SW'(i);
      end
    end
    valid_o = (lvl_o != LVL_NONE);
  end
endmodule

// File: rtl/vic_isr_stack.sv
module vic_isr_stack
  import vic_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic pop_i,
  output lvl_t top_o
);
  logic [2:0] isr_q, isr_d;

  always_comb begin
    isr_d = isr_q;
    if (pop_i) begin
      if      (isr_q[2]) isr_d[2] = 1'b0;
      else if (isr_q[1]) isr_d[1] = 1'b0;
      else               isr_d[0] = 1'b0;
    end
    if (push_i && push_lvl_i != LVL_NONE) isr_d[push_lvl_i - 2'd1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign top_o = isr_q[2] ? LVL_TOP : isr_q[1] ? LVL_HI : isr_q[0] ? LVL_LO : LVL_NONE;
endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import vic_pkg::*;
#(
  parameter int N_SLOTS    = 10,
  parameter int TOP_SLOTS  = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int SW        = $clog2(N_SLOTS),
  localparam int ADDR_W    = $clog2(VEC_BASE + VEC_STRIDE * (N_SLOTS - 1) + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               glb_en_i,
  input  logic [N_SLOTS-1:0] en_i,
  input  logic [N_SLOTS-1:0] lvl_sel_i,
  input  logic [N_SLOTS-1:0] pend_set_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic               irq_o,
  output logic [ADDR_W-1:0]  vec_o,
  output logic [1:0]         cur_lvl_o
);
  logic [N_SLOTS-1:0] pend, clr, cand;
  logic               best_valid, take, req_q;
  logic [SW-1:0]      best_slot, slot_q;
  lvl_t               best_lvl, lvl_q, isr_top;
  logic [ADDR_W-1:0]  vec_q;

  assign take = req_q && ack_i;
  assign cand = pend & en_i & {N_SLOTS{glb_en_i}};

  always_comb begin
    clr = '0;
    if (take) clr[slot_q] = 1'b1;
  end

  vic_pend_reg #(.N_SLOTS(N_SLOTS)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pend_set_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  vic_arbiter #(.N_SLOTS(N_SLOTS), .TOP_SLOTS(TOP_SLOTS)) u_arb (
    .cand_i  (cand),
    .sel_i   (lvl_sel_i),
    .valid_o (best_valid),
    .slot_o  (best_slot),
    .lvl_o   (best_lvl)
  );

  vic_isr_stack u_isr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_lvl_i (lvl_q),
    .pop_i      (eoi_i),
    .top_o      (isr_top)
  );

  // offer is frozen from raise until acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      slot_q <= '0;
      lvl_q  <= LVL_NONE;
      vec_q  <= '0;
    end else if (take) begin
      req_q <= 1'b0;
    end else if (!req_q && best_valid && best_lvl > isr_top) begin
      req_q  <= 1'b1;
      slot_q <= best_slot;
      lvl_q  <= best_lvl;
      vec_q  <= ADDR_W'(VEC_BASE + VEC_STRIDE * int'(best_slot));
    end
  end

  assign irq_o     = req_q;
  assign vec_o     = vec_q;
  assign cur_lvl_o = isr_top;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int N_SLOTS    = 10,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int ADDR_W     = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              glb_en_i,
  input logic              ack_i,
  input logic              eoi_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [1:0]        cur_lvl_o
);
  localparam int VEC_MAX = VEC_BASE + VEC_STRIDE * (N_SLOTS - 1);

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_idle: assert (!irq_o && cur_lvl_o == 2'd0);

  a_r2_vec_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int'(vec_o) >= VEC_BASE && int'(vec_o) <= VEC_MAX &&
               (int'(vec_o) - VEC_BASE) % VEC_STRIDE == 0));

  a_r7_ack_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i && !eoi_i) |=> (!irq_o && cur_lvl_o > $past(cur_lvl_o)));

  a_r8_eoi_pops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(irq_o && ack_i) && cur_lvl_o != 2'd0) |=> (cur_lvl_o < $past(cur_lvl_o)));

  a_r9_offer_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (irq_o && $stable(vec_o)));

  a_r10_glb_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glb_en_i && !irq_o) |=> !irq_o);
endmodule

bind prio_vic vic_checker #(
  .N_SLOTS(N_SLOTS), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .glb_en_i  (glb_en_i),
  .ack_i     (ack_i),
  .eoi_i     (eoi_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .cur_lvl_o (cur_lvl_o)
);

// File: tb/sim_prio_vic.sv
`timescale 1ns/100ps
module sim_prio_vic;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         glb_en = 1'b0;
  logic [N-1:0] en = '0, sel = '0, pset = '0;
  logic         ack = 1'b0, eoi = 1'b0;
  logic         irq;
  logic [6:0]   vec;
  logic [1:0]   lvl;
  int           n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  prio_vic u0 (
    .clk_i(clk), .rst_ni(rst_ni), .glb_en_i(glb_en), .en_i(en),
    .lvl_sel_i(sel), .pend_set_i(pset), .ack_i(ack), .eoi_i(eoi),
    .irq_o(irq), .vec_o(vec), .cur_lvl_o(lvl)
  );

  typedef struct packed {
    logic [N-1:0] pend;
    logic [N-1:0] en;
    logic [N-1:0] sel;
    logic         irq;
    logic [6:0]   vec;
    logic [3:0]   req;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{10'h008, 10'h3FF, 10'h000, 1'b1, 7'h1B, 4'd2},
    '{10'h024, 10'h3FF, 10'h020, 1'b1, 7'h2B, 4'd4},
    '{10'h090, 10'h3FF, 10'h090, 1'b1, 7'h23, 4'd5},
    '{10'h201, 10'h3FF, 10'h200, 1'b1, 7'h4B, 4'd3},
    '{10'h202, 10'h3FF, 10'h202, 1'b1, 7'h0B, 4'd3},
    '{10'h040, 10'h3BF, 10'h000, 1'b0, 7'h00, 4'd10},
    '{10'h003, 10'h3FF, 10'h003, 1'b1, 7'h03, 4'd5},
    '{10'h3FF, 10'h3FF, 10'h000, 1'b1, 7'h03, 4'd5},
    '{10'h300, 10'h3FF, 10'h100, 1'b1, 7'h43, 4'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; glb_en = 1'b0; en = '0; sel = '0; pset = '0; ack = 1'b0; eoi = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [N-1:0] m);
    pset = m; @(negedge clk); pset = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1; @(negedge clk); eoi = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 lvl in reset", int'(lvl), 0);
    do_reset();
    chk("R1 irq after reset", int'(irq), 0);

    // table: R2..R5, R10 arbitration patterns
    for (int i = 0; i < 9; i++) begin
      do_reset();
      glb_en = 1'b1; en = TBL[i].en; sel = TBL[i].sel;
      pulse(TBL[i].pend);
      @(negedge clk);
      chk($sformatf("R%0d irq row %0d", TBL[i].req, i), int'(irq), int'(TBL[i].irq));
      if (TBL[i].irq) chk($sformatf("R%0d vec row %0d", TBL[i].req, i), int'(vec), int'(TBL[i].vec));
    end

    // nesting: R11 timing, R6, R7, R8
    do_reset();
    glb_en = 1'b1; en = '1; sel = 10'h011;
    pulse(10'h008);
    chk("R11 irq not yet", int'(irq), 0);
    @(negedge clk);
    chk("R11 irq raised", int'(irq), 1);
    chk("R2 vec slot3", int'(vec), 'h1B);
    do_ack();
    chk("R7 irq drops", int'(irq), 0);
    chk("R7 lvl low", int'(lvl), 1);
    pulse(10'h004);
    repeat (2) @(negedge clk);
    chk("R6 equal level held", int'(irq), 0);
    pulse(10'h010);
    @(negedge clk);
    chk("R6 high preempts", int'(irq), 1);
    chk("R5 vec slot4", int'(vec), 'h23);
    do_ack();
    chk("R7 lvl high", int'(lvl), 2);
    pulse(10'h001);
    @(negedge clk);
    chk("R3 top vec", int'(vec), 'h03);
    do_ack();
    chk("R7 lvl top", int'(lvl), 3);
    do_eoi();
    chk("R8 pop to high", int'(lvl), 2);
    do_eoi();
    chk("R8 pop to low", int'(lvl), 1);
    chk("R6 still held", int'(irq), 0);
    do_eoi();
    chk("R8 pop to idle", int'(lvl), 0);
    @(negedge clk);
    chk("R6 held slot offered", int'(irq), 1);
    chk("R6 held slot vec", int'(vec), 'h13);
    do_ack();
    do_eoi();
    repeat (2) @(negedge clk);
    chk("R7 pending cleared", int'(irq), 0);

    // R9 offer held while a more urgent slot arrives
    do_reset();
    glb_en = 1'b1; en = '1; sel = 10'h001;
    pulse(10'h020);
    @(negedge clk);
    chk("R9 first vec", int'(vec), 'h2B);
    pulse(10'h001);
    repeat (2) @(negedge clk);
    chk("R9 irq held", int'(irq), 1);
    chk("R9 vec held", int'(vec), 'h2B);
    do_ack();
    @(negedge clk);
    chk("R4 top after ack", int'(vec), 'h03);
    chk("R6 top preempts low", int'(irq), 1);

    // R10 global gate keeps pending flag
    do_reset();
    en = '1;
    pulse(10'h008);
    repeat (3) @(negedge clk);
    chk("R10 gated", int'(irq), 0);
    glb_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 released irq", int'(irq), 1);
    chk("R10 released vec", int'(vec), 'h1B);

    finish_run();
  end
endmodule